// File: doc/BRIEF.md
# NAND Single-Bit Hamming ECC Generator and Checker

This block protects one NAND data step of `STEP_BYTES` bytes (512 by default) with a 24-bit single-error-correcting parity code. While the bytes stream through the generator, it keeps two parity fields of equal width. Each field has one bit per bit-address line, 3 bit-in-byte lines plus 9 byte-index lines. One field collects the data bits whose address line is 0, and the other collects the data bits whose address line is 1. The two fields are packed into one word and inverted. The result is the code that software stores in the spare area, with byte 0 in bits 7:0.

On read back, the checker takes the stored code and the code recomputed from the read data. Their XOR is the difference word. If one data bit flipped, the upper half of the difference is the complement of the lower half. The upper half then gives the failing bit address directly. A difference with a single set bit means the stored code was damaged and the data is good. The checker registers a status, a byte offset and a one-hot flip mask. A combinational read-modify port applies the flip to a byte taken from the buffer when that byte's offset matches the reported one.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, `gen_code` reads all ones (0xFFFFFF) and `chk_status`, `chk_offset` and `chk_mask` are all zero.
- R2: The generator works on the bit address {byte index[8:0], bit position[2:0]} of each data bit that is 1. For each address line k, it toggles field bit k of the low field (even) if line k is 0, and of the high field (odd) if line k is 1. `gen_code` = ~{odd, even}, so code byte 0 is bits 7:0. The byte index counts accepted bytes from 0 and wraps after `STEP_BYTES`.
- R3: When `gen_clear` is high, both parity fields and the byte index are zeroed on the next edge, so `gen_code` returns to all ones. A byte offered in the same cycle is dropped.
- R4: A cycle with `gen_valid` and `gen_clear` both low leaves `gen_code` unchanged.
- R5: Status, offset and mask are updated only on the clock edge where `chk_strobe` is high. They are valid from the next cycle and hold until the next strobe.
- R6: The difference is `chk_stored` XOR `chk_calc`. A zero difference gives status 0 (clean).
- R7: If difference[11:0] XOR difference[23:12] equals 0xFFF and difference[23:15] is below `STEP_BYTES`, the status is 1 (data corrected). In that case `chk_offset` = difference[23:15] and `chk_mask` = 1 << difference[14:12].
- R8: A pattern matching R7 whose byte offset is `STEP_BYTES` or higher gives status 3 (uncorrectable).
- R9: A difference with exactly one bit set gives status 2 (code damaged, data good). Offset and mask are zero.
- R10: Any other nonzero difference gives status 3. For every status other than 1, offset and mask are zero.
- R11: `fix_data_out` = `fix_data_in` XOR `chk_mask` when the status is 1 and `fix_offset` equals `chk_offset`. Otherwise `fix_data_out` = `fix_data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen_clear | input | 1 | Start of a new step: clear parity and byte index |
| gen_valid | input | 1 | Data byte present on gen_data |
| gen_data | input | 8 | Streamed data byte |
| gen_code | output | 24 | Inverted packed code of the bytes so far, byte 0 in bits 7:0 |
| chk_strobe | input | 1 | Compare chk_stored against chk_calc |
| chk_stored | input | 24 | Code read from the spare area, little-endian |
| chk_calc | input | 24 | Code recomputed from the read data, little-endian |
| chk_status | output | 2 | 0 clean, 1 data corrected, 2 code damaged, 3 uncorrectable |
| chk_offset | output | 9 | Byte offset of the failing data bit |
| chk_mask | output | 8 | One-hot mask of the failing bit |
| fix_offset | input | 9 | Offset of the byte on fix_data_in |
| fix_data_in | input | 8 | Byte taken from the read buffer |
| fix_data_out | output | 8 | Byte with the correction applied if it is the failing one |

## Verification
The bench builds two copies of the block. The first uses the default power-of-two step of 512 bytes. There, every data-bit flip (all 4096 of them) and every code-bit flip (all 24) is injected and must be classified and located exactly. The second copy uses a 320-byte step. With that step a complementary difference can point past the end of the step, which makes the out-of-range rule (R8) observable. With a 512-byte step that rule can never trigger.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN    = 2'd0,
    ECC_FIXED    = 2'd1,
    ECC_CODE_HIT = 2'd2,
    ECC_FATAL    = 2'd3
  } ecc_stat_e;

  // Bits of a byte whose in-byte position has line k equal to hi.
  function automatic logic [7:0] lane_sel(input int k, input logic hi);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] pos;
      pos  = 3'(i);
      r[i] = (pos[k] == hi);
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc_parity_gen.sv
module ecc_parity_gen
  import nand_ecc_pkg::*;
#(
  parameter int STEP_BYTES = 512,
  localparam int BYTE_AW = $clog2(STEP_BYTES),
  localparam int ADDR_W  = BYTE_AW + 3,
  localparam int CODE_W  = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_clear,
  input  logic              gen_valid,
  input  logic [7:0]        gen_data,
  output logic [CODE_W-1:0] gen_code
);

  localparam logic [BYTE_AW-1:0] LAST_IDX = BYTE_AW'(STEP_BYTES - 1);

  logic [ADDR_W-1:0]  even_q, even_d, odd_q, odd_d;
  logic [ADDR_W-1:0]  even_hit, odd_hit;
  logic [BYTE_AW-1:0] idx_q, idx_d;
  logic               byte_par;

  assign byte_par = ^gen_data;

  // In-byte address lines: parity over the bit lanes on each side.
  for (genvar k = 0; k < 3; k++) begin : g_lane
    assign even_hit[k] = ^(gen_data & lane_sel(k, 1'b0));
    assign odd_hit[k]  = ^(gen_data & lane_sel(k, 1'b1));
  end

  // Byte-index address lines: whole-byte parity steered by the index bit.
  for (genvar k = 3; k < ADDR_W; k++) begin : g_row
    assign even_hit[k] = byte_par & ~idx_q[k-3];
    assign odd_hit[k]  = byte_par &  idx_q[k-3];
  end

  always_comb begin
    even_d = even_q;
    odd_d  = odd_q;
    idx_d  = idx_q;
    if (gen_clear) begin
      even_d = '0;
      odd_d  = '0;
      idx_d  = '0;
    end else if (gen_valid) begin
      even_d = even_q ^ even_hit;
      odd_d  = odd_q ^ odd_hit;
      idx_d  = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_q <= '0;
      odd_q  <= '0;
      idx_q  <= '0;
    end else if (gen_clear || gen_valid) begin
      even_q <= even_d;
      odd_q  <= odd_d;
      idx_q  <= idx_d;
    end
  end

  assign gen_code = ~{odd_q, even_q};

  a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    gen_clear |=> (gen_code == {CODE_W{1'b1}}));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_clear && !gen_valid) |=> $stable(gen_code));

  // R2: one byte can only move parity bits, never both halves of one line.
  a_r2_line_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_valid && !gen_clear) |=> ((($past(even_q) ^ even_q) & ($past(odd_q) ^ odd_q) & {{(ADDR_W-3){1'b1}}, 3'b000}) == '0));

endmodule

// File: rtl/ecc_syndrome_chk.sv
module ecc_syndrome_chk
  import nand_ecc_pkg::*;
#(
  parameter int STEP_BYTES = 512,
  localparam int BYTE_AW = $clog2(STEP_BYTES),
  localparam int ADDR_W  = BYTE_AW + 3,
  localparam int CODE_W  = 2 * ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_strobe,
  input  logic [CODE_W-1:0]  chk_stored,
  input  logic [CODE_W-1:0]  chk_calc,
  output ecc_stat_e          chk_status,
  output logic [BYTE_AW-1:0] chk_offset,
  output logic [7:0]         chk_mask
);

  localparam logic [BYTE_AW:0] STEP_LIM = (BYTE_AW + 1)'(STEP_BYTES);

  logic [CODE_W-1:0]  diff;
  logic [ADDR_W-1:0]  lo_half, hi_half;
  logic [BYTE_AW-1:0] loc_byte;
  logic [2:0]         loc_bit;
  logic               is_mirror, is_single, in_range;

  ecc_stat_e          stat_d, stat_q;
  logic [BYTE_AW-1:0] off_d, off_q;
  logic [7:0]         mask_d, mask_q;

  assign diff      = chk_stored ^ chk_calc;
  assign lo_half   = diff[ADDR_W-1:0];
  assign hi_half   = diff[CODE_W-1:ADDR_W];
  assign loc_byte  = diff[CODE_W-1:ADDR_W+3];
  assign loc_bit   = diff[ADDR_W+2:ADDR_W];
  assign is_mirror = ((lo_half ^ hi_half) == {ADDR_W{1'b1}});
  assign is_single = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
  assign in_range  = ({1'b0, loc_byte} < STEP_LIM);

  always_comb begin
    stat_d = ECC_FATAL;
    off_d  = '0;
    mask_d = '0;
    if (diff == '0) begin
      stat_d = ECC_CLEAN;
    end else if (is_mirror) begin
      if (in_range) begin
        stat_d = ECC_FIXED;
        off_d  = loc_byte;
        mask_d = 8'b1 << loc_bit;
      end
    end else if (is_single) begin
      stat_d = ECC_CODE_HIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= ECC_CLEAN;
      off_q  <= '0;
      mask_q <= '0;
    end else if (chk_strobe) begin
      stat_q <= stat_d;
      off_q  <= off_d;
      mask_q <= mask_d;
    end
  end

  assign chk_status = stat_q;
  assign chk_offset = off_q;
  assign chk_mask   = mask_q;

  a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_strobe |=> ($stable(chk_status) && $stable(chk_offset) && $stable(chk_mask)));

  a_r6_equal_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_strobe && (chk_stored == chk_calc)) |=> (chk_status == ECC_CLEAN));

  a_r7_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_status == ECC_FIXED) |-> $onehot(chk_mask));

  a_r8_offset_in_step: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_status == ECC_FIXED) |-> ({1'b0, chk_offset} < STEP_LIM));

  a_r10_quiet_location: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_status != ECC_FIXED) |-> (chk_mask == '0 && chk_offset == '0));

  a_r9_single_flip_code: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_strobe && $countones(chk_stored ^ chk_calc) == 1) |=> (chk_status == ECC_CODE_HIT));

endmodule

// File: rtl/ecc_byte_fix.sv
module ecc_byte_fix
  import nand_ecc_pkg::*;
#(
  parameter int BYTE_AW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ecc_stat_e          chk_status,
  input  logic [BYTE_AW-1:0] chk_offset,
  input  logic [7:0]         chk_mask,
  input  logic [BYTE_AW-1:0] fix_offset,
  input  logic [7:0]         fix_data_in,
  output logic [7:0]         fix_data_out
);

  logic hit;

  assign hit          = (chk_status == ECC_FIXED) && (fix_offset == chk_offset);
  assign fix_data_out = hit ? (fix_data_in ^ chk_mask) : fix_data_in;

  a_r11_pass_unless_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_status != ECC_FIXED) |-> (fix_data_out == fix_data_in));

  a_r11_at_most_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fix_data_out ^ fix_data_in) <= 1);

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import nand_ecc_pkg::*;
#(
  parameter int STEP_BYTES = 512,
  localparam int BYTE_AW = $clog2(STEP_BYTES),
  localparam int ADDR_W  = BYTE_AW + 3,
  localparam int CODE_W  = 2 * ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gen_clear,
  input  logic               gen_valid,
  input  logic [7:0]         gen_data,
  output logic [CODE_W-1:0]  gen_code,
  input  logic               chk_strobe,
  input  logic [CODE_W-1:0]  chk_stored,
  input  logic [CODE_W-1:0]  chk_calc,
  output logic [1:0]         chk_status,
  output logic [BYTE_AW-1:0] chk_offset,
  output logic [7:0]         chk_mask,
  input  logic [BYTE_AW-1:0] fix_offset,
  input  logic [7:0]         fix_data_in,
  output logic [7:0]         fix_data_out
);

  logic [1:0] rst_pipe;
  logic       rst_core_n;
  ecc_stat_e  stat_w;

  // Asynchronous assertion, release aligned to the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  ecc_parity_gen #(.STEP_BYTES(STEP_BYTES)) u_gen (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .gen_clear (gen_clear),
    .gen_valid (gen_valid),
    .gen_data  (gen_data),
    .gen_code  (gen_code)
  );

  ecc_syndrome_chk #(.STEP_BYTES(STEP_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .chk_strobe (chk_strobe),
    .chk_stored (chk_stored),
    .chk_calc   (chk_calc),
    .chk_status (stat_w),
    .chk_offset (chk_offset),
    .chk_mask   (chk_mask)
  );

  ecc_byte_fix #(.BYTE_AW(BYTE_AW)) u_fix (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .chk_status   (stat_w),
    .chk_offset   (chk_offset),
    .chk_mask     (chk_mask),
    .fix_offset   (fix_offset),
    .fix_data_in  (fix_data_in),
    .fix_data_out (fix_data_out)
  );

  assign chk_status = stat_w;

  a_r1_reset_code_ones: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (gen_code == {CODE_W{1'b1}} && chk_status == 2'd0));

endmodule

// File: tb/nand_hamming_ecc_tb.sv
module nand_hamming_ecc_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        gen_clear = 0, gen_valid = 0;
  logic [7:0]  gen_data = 0;
  logic [23:0] gen_code;
  logic        chk_strobe = 0;
  logic [23:0] chk_stored = 0, chk_calc = 0;
  logic [1:0]  chk_status;
  logic [8:0]  chk_offset;
  logic [7:0]  chk_mask;
  logic [8:0]  fix_offset = 0;
  logic [7:0]  fix_data_in = 0, fix_data_out;

  logic        s_strobe = 0;
  logic [23:0] s_stored = 0, s_calc = 0;
  logic [23:0] s_code;
  logic [1:0]  s_status;
  logic [8:0]  s_offset;
  logic [7:0]  s_mask, s_fix_out;

  nand_hamming_ecc u_dut (
    .clk(clk), .rst_n(rst_n),
    .gen_clear(gen_clear), .gen_valid(gen_valid), .gen_data(gen_data), .gen_code(gen_code),
    .chk_strobe(chk_strobe), .chk_stored(chk_stored), .chk_calc(chk_calc),
    .chk_status(chk_status), .chk_offset(chk_offset), .chk_mask(chk_mask),
    .fix_offset(fix_offset), .fix_data_in(fix_data_in), .fix_data_out(fix_data_out)
  );

  nand_hamming_ecc #(.STEP_BYTES(320)) u_dut_small (
    .clk(clk), .rst_n(rst_n),
    .gen_clear(1'b0), .gen_valid(1'b0), .gen_data(8'h00), .gen_code(s_code),
    .chk_strobe(s_strobe), .chk_stored(s_stored), .chk_calc(s_calc),
    .chk_status(s_status), .chk_offset(s_offset), .chk_mask(s_mask),
    .fix_offset(9'd0), .fix_data_in(8'h00), .fix_data_out(s_fix_out)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] pat [512];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Code contribution {odd, even} of one byte at a given index.
  function automatic logic [23:0] contrib(input int b, input logic [7:0] v);
    logic [11:0] ev, od, a;
    ev = '0; od = '0;
    for (int i = 0; i < 8; i++) begin
      if (v[i]) begin
        a = 12'((b << 3) + i);
        for (int k = 0; k < 12; k++) begin
          if (a[k]) od[k] = ~od[k];
          else      ev[k] = ~ev[k];
        end
      end
    end
    return {od, ev};
  endfunction

  function automatic logic [23:0] model_code();
    logic [23:0] acc;
    acc = '0;
    for (int b = 0; b < 512; b++) acc ^= contrib(b, pat[b]);
    return ~acc;
  endfunction

  task automatic stream(input bit gaps);
    for (int b = 0; b < 512; b++) begin
      gen_valid = 1'b1;
      gen_data  = pat[b];
      @(negedge clk);
      if (gaps && (b % 7 == 3)) begin
        gen_valid = 1'b0;
        gen_data  = 8'hFF;
        @(negedge clk);
      end
    end
    gen_valid = 1'b0;
  endtask

  task automatic do_check(input logic [23:0] st, input logic [23:0] ca);
    chk_stored = st; chk_calc = ca; chk_strobe = 1'b1;
    @(negedge clk);
    chk_strobe = 1'b0;
  endtask

  task automatic do_small(input logic [23:0] st, input logic [23:0] ca);
    s_stored = st; s_calc = ca; s_strobe = 1'b1;
    @(negedge clk);
    s_strobe = 1'b0;
  endtask

  // {diff, status, offset, mask}
  localparam logic [42:0] VEC [8] = '{
    {24'h000000, 2'd0, 9'd0,   8'h00},
    {24'h000FFF, 2'd1, 9'd0,   8'h01},
    {24'hFFF000, 2'd1, 9'd511, 8'h80},
    {24'h123EDC, 2'd1, 9'd36,  8'h08},
    {24'h800000, 2'd2, 9'd0,   8'h00},
    {24'h000001, 2'd2, 9'd0,   8'h00},
    {24'h000003, 2'd3, 9'd0,   8'h00},
    {24'h123456, 2'd3, 9'd0,   8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [23:0] g, gm, d, base;
    logic [1:0]  hold_s;
    for (int b = 0; b < 512; b++) pat[b] = 8'(b * 37 + 11) ^ 8'(b >> 3);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 code", gen_code, 24'hFFFFFF);
    chk("R1 status", chk_status, 2'd0);
    chk("R1 offset", chk_offset, 9'd0);
    chk("R1 mask", chk_mask, 8'h00);

    // R2 plain stream against model
    stream(1'b0);
    g = gen_code;
    gm = model_code();
    chk("R2 stream code", g, gm);

    // R3 clear with a byte offered in the same cycle
    gen_clear = 1'b1; gen_valid = 1'b1; gen_data = 8'hFF;
    @(negedge clk);
    gen_clear = 1'b0; gen_valid = 1'b0;
    chk("R3 clear wins", gen_code, 24'hFFFFFF);

    // R4 idle gaps do not disturb the result
    stream(1'b1);
    chk("R4 gapped stream", gen_code, gm);
    repeat (3) @(negedge clk);
    chk("R4 idle hold", gen_code, gm);

    // R2 second pattern, restarted by clear
    gen_clear = 1'b1; @(negedge clk); gen_clear = 1'b0;
    for (int b = 0; b < 512; b++) pat[b] = 8'(b) ^ 8'h5A;
    stream(1'b0);
    chk("R2 second pattern", gen_code, model_code());
    gen_clear = 1'b1; @(negedge clk); gen_clear = 1'b0;
    for (int b = 0; b < 512; b++) pat[b] = 8'(b * 37 + 11) ^ 8'(b >> 3);

    // R6-R10 vector table
    for (int v = 0; v < 8; v++) begin
      base = 24'hA5A5A5 ^ 24'(v * 24'h010203);
      do_check(base ^ VEC[v][42:19], base);
      chk("R6-R10 table status (R7 R9 R10)", chk_status, VEC[v][18:17]);
      chk("R7 table offset", chk_offset, VEC[v][16:8]);
      chk("R7 table mask", chk_mask, VEC[v][7:0]);
    end

    // R11 read-modify after a correctable result (offset 36, mask 08)
    do_check(24'h123EDC, 24'h000000);
    fix_offset = 9'd36; fix_data_in = 8'hF0; #1;
    chk("R11 fix hit", fix_data_out, 8'hF8);
    fix_offset = 9'd37; #1;
    chk("R11 fix other byte", fix_data_out, 8'hF0);

    // R5 hold without strobe
    hold_s = chk_status;
    chk_stored = 24'h000003; chk_calc = 24'h0;
    @(negedge clk); @(negedge clk);
    chk("R5 hold status", chk_status, hold_s);
    chk("R5 hold offset", chk_offset, 9'd36);

    // R11 no change when not corrected
    do_check(24'h800000, 24'h0);
    fix_offset = 9'd0; fix_data_in = 8'h3C; #1;
    chk("R11 pass on code hit", fix_data_out, 8'h3C);

    // R7 every single data-bit flip
    for (int b = 0; b < 512; b++) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] bad;
        bad = pat[b] ^ (8'b1 << i);
        d = ~(~gm ^ contrib(b, pat[b]) ^ contrib(b, bad));
        do_check(g, d);
        n_checks++;
        if (chk_status !== 2'd1 || chk_offset !== 9'(b) || chk_mask !== (8'b1 << i)) begin
          n_fail++;
          $display("FAIL R7 flip b=%0d i=%0d actual=%0h/%0h/%0h expected=1/%0h/%0h",
                   b, i, chk_status, chk_offset, chk_mask, b, 8'b1 << i);
        end
      end
    end

    // R9 every single code-bit flip
    for (int j = 0; j < 24; j++) begin
      do_check(g ^ (24'b1 << j), g);
      chk("R9 code flip", {chk_status, chk_offset, chk_mask}, {2'd2, 9'd0, 8'd0});
    end

    // R8 on a 320-byte step: byte 400 bit 2 is beyond the step
    do_small(24'hC8237D, 24'h0);
    chk("R8 out of step", s_status, 2'd3);
    chk("R8 quiet mask", s_mask, 8'h00);
    do_check(24'hC8237D, 24'h0);
    chk("R7 same diff in 512 step", {chk_status, chk_offset, chk_mask}, {2'd1, 9'd400, 8'h04});
    // last byte of the 320 step, bit 7: address 0x9FF
    do_small(24'h9FF600, 24'h0);
    chk("R8 last in-step byte", {s_status, s_offset, s_mask}, {2'd1, 9'd319, 8'h80});

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule